// File: doc/BRIEF.md
# Serial Line Receiver with Break Handling

This block is the receive half of an asynchronous serial port. It watches an incoming line that is sampled on a strobe running at a fixed multiple of the bit rate. It finds start bits and assembles characters of 5 to 8 data bits, with an optional parity bit and one or two stop bits. Each finished character goes into a small receive queue. Every queue entry carries three error tags: break, framing error and parity error.

When the line is held low for longer than one full character time, the block treats this as a line break. The character time is the start bit, the data bits, the parity bit and the stop bits together. Each break places exactly one all-zero character, tagged as a break, into the queue. Reception then stays blocked until the line has been high for two consecutive samples, and only a fresh start bit after that opens it again. A sticky break status bit, meant for a processor read port, is raised only when the break-tagged character becomes the queue head. Each read strobe clears it. An overrun bit records characters that were lost because the queue was full.

The receive state machine uses these states:
- `S_IDLE`: waits for a low sample.
- `S_START`: checks the start bit again at mid-bit. A high sample there returns to `S_IDLE`.
- `S_DATA`: collects the data bits.
- `S_PARITY`: takes the parity bit, when parity is enabled.
- `S_STOP`: samples one or two stop bits. It then goes to `S_IDLE`, or to `S_HOLD` when every sample so far was low and the line is still low.
- `S_HOLD`: if the line rises, it pushes a framing-error character and goes to `S_IDLE`. If the break threshold is exceeded, it pushes the break character and goes to `S_REARM`.
- `S_REARM`: after two consecutive high samples, goes to `S_IDLE`.

Top module: `uart_rx_brk`

## Requirements
- R1: After reset the queue is empty (`rx_valid`=0, `fifo_count`=0) and both `brk_stat` and `ovr_stat` read 0.
- R2: A character is sent least significant bit first, framed by one low start bit and high stop bit(s). It is queued with its data and with all three tags at 0.
- R3: `cfg_len` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. The received value is right-aligned in `rx_data`, and the unused upper bits are 0.
- R4: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_odd`=0 selects even parity and 1 selects odd parity. On a mismatch the character is queued with `head_perr`=1.
- R5: A stop sample read as low sets `head_ferr`=1 on that character. With `cfg_two_stop`=1, both stop samples are checked.
- R6: A low pulse that is high again when the start bit is rechecked at mid-bit queues nothing.
- R7: A break is counted from the first low sample of the start bit. It requires more consecutive low samples than the frame length in bits times the oversampling ratio. The frame length counts the start bit, the data bits, the parity bit and the stop bits. A break queues exactly one entry, with data 0 and `head_brk`=1, however long the low lasts.
- R8: An all-zero frame whose line rises before the break threshold is queued as data 0 with `head_ferr`=1 and `head_brk`=0.
- R9: After a break, nothing is queued, and no second break is reported, until the line has given two consecutive high samples followed by a valid start bit.
- R10: `brk_stat` rises only when a break-tagged entry becomes the queue head. While earlier characters are still queued ahead of it, `brk_stat` stays 0.
- R11: A pulse on `lsr_rd` clears `brk_stat` and `ovr_stat`. If a clear and a new set land in the same cycle, the set wins.
- R12: A character that completes while the queue holds `DEPTH` entries is dropped and `ovr_stat` is set. The queued entries are unchanged.
- R13: Entries leave the queue in arrival order. The head changes only on a `pop` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Sample strobe at OSR times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Data length code, 5 + value bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | Two stop bits |
| pop | input | 1 | Remove the queue head |
| lsr_rd | input | 1 | Status read strobe (clears status bits) |
| rx_valid | output | 1 | Queue not empty |
| rx_data | output | 8 | Head character |
| head_brk | output | 1 | Head break tag |
| head_ferr | output | 1 | Head framing error tag |
| head_perr | output | 1 | Head parity error tag |
| brk_stat | output | 1 | Sticky break status |
| ovr_stat | output | 1 | Sticky overrun status |
| fifo_count | output | 5 | Number of queued entries |

## Verification
Two events can collide in one cycle: a status read strobe that clears `brk_stat`, and a break-tagged character reaching the queue head, which sets it. The bench queues a normal character, sends a break behind it and then one more character. It then pops the head and raises `lsr_rd` one cycle later, exactly when the break entry's arrival at the head is registered. `brk_stat` must read 1 after that cycle, and a later lone read must clear it. The bench also checks that `brk_stat` stays 0 while the break entry is still behind the normal one.

// File: rtl/uart_rx_brk_pkg.sv
package uart_rx_brk_pkg;

    localparam int DATA_W = 8;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP,
        S_HOLD,
        S_REARM
    } rx_state_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_brk_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_two_stop,
    output logic       push,
    output rx_entry_t  push_entry
);
    localparam int CW   = $clog2(OSR);
    localparam int MAXB = 2 + DATA_W + 2;
    localparam int LRW  = $clog2(MAXB * OSR + 2);

    rx_state_t         st, st_n;
    logic [CW-1:0]     tcnt;
    logic [2:0]        bcnt;
    logic              stop_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_acc, perr_q, ferr_q, allz, prev_hi;
    logic [LRW-1:0]    lowrun;

    logic [3:0]        nbits, fbits;
    logic [LRW-1:0]    thr;
    logic              mid, half, last_data, last_stop, brk_hit;
    logic [DATA_W-1:0] aligned;

    always_comb begin
        nbits     = 4'd5 + {2'b00, cfg_len};
        fbits     = 4'd2 + nbits + {3'b000, cfg_par_en} + {3'b000, cfg_two_stop};
        thr       = LRW'(32'(fbits) * OSR);
        mid       = tick && (tcnt == CW'(OSR - 1));
        half      = tick && (tcnt == CW'(OSR / 2 - 1));
        last_data = ({1'b0, bcnt} == (nbits - 4'd1));
        last_stop = !cfg_two_stop || stop_idx;
        brk_hit   = tick && !rxd && (lowrun >= thr);
        aligned   = shreg >> (4'd8 - nbits);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_n;
    end

    // next-state decode
    always_comb begin
        st_n = st;
        unique case (st)
            S_IDLE:   if (tick && !rxd) st_n = S_START;
            S_START:  if (half) st_n = rxd ? S_IDLE : S_DATA;
            S_DATA:   if (mid && last_data) st_n = cfg_par_en ? S_PARITY : S_STOP;
            S_PARITY: if (mid) st_n = S_STOP;
            S_STOP:   if (mid && last_stop) st_n = (allz && !rxd) ? S_HOLD : S_IDLE;
            S_HOLD: begin
                if (tick && rxd)  st_n = S_IDLE;
                else if (brk_hit) st_n = S_REARM;
            end
            S_REARM:  if (tick && rxd && prev_hi) st_n = S_IDLE;
            default:  st_n = S_IDLE;
        endcase
    end

    // line history, independent of state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lowrun  <= '0;
            prev_hi <= 1'b1;
        end else if (tick) begin
            prev_hi <= rxd;
            if (rxd)            lowrun <= '0;
            else if (~&lowrun)  lowrun <= lowrun + 1'b1;
        end
    end

    // outputs and frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt       <= '0;
            bcnt       <= '0;
            stop_idx   <= 1'b0;
            shreg      <= '0;
            par_acc    <= 1'b0;
            perr_q     <= 1'b0;
            ferr_q     <= 1'b0;
            allz       <= 1'b1;
            push       <= 1'b0;
            push_entry <= '0;
        end else begin
            push <= 1'b0;
            unique case (st)
                S_IDLE: begin
                    tcnt     <= '0;
                    bcnt     <= '0;
                    stop_idx <= 1'b0;
                    shreg    <= '0;
                    par_acc  <= 1'b0;
                    perr_q   <= 1'b0;
                    ferr_q   <= 1'b0;
                    allz     <= 1'b1;
                end
                S_START: begin
                    if (tick) tcnt <= half ? '0 : tcnt + 1'b1;
                end
                S_DATA: begin
                    if (tick) tcnt <= mid ? '0 : tcnt + 1'b1;
                    if (mid) begin
                        shreg   <= {rxd, shreg[DATA_W-1:1]};
                        par_acc <= par_acc ^ rxd;
                        allz    <= allz & !rxd;
                        bcnt    <= bcnt + 1'b1;
                    end
                end
                S_PARITY: begin
                    if (tick) tcnt <= mid ? '0 : tcnt + 1'b1;
                    if (mid) begin
                        perr_q <= par_acc ^ rxd ^ cfg_par_odd;
                        allz   <= allz & !rxd;
                    end
                end
                S_STOP: begin
                    if (tick) tcnt <= mid ? '0 : tcnt + 1'b1;
                    if (mid) begin
                        ferr_q   <= ferr_q | !rxd;
                        allz     <= allz & !rxd;
                        stop_idx <= 1'b1;
                        if (last_stop && !(allz && !rxd)) begin
                            push            <= 1'b1;
                            push_entry.brk  <= 1'b0;
                            push_entry.ferr <= ferr_q | !rxd;
                            push_entry.perr <= perr_q;
                            push_entry.data <= aligned;
                        end
                    end
                end
                S_HOLD: begin
                    tcnt <= '0;
                    if (tick && rxd) begin
                        push            <= 1'b1;
                        push_entry.brk  <= 1'b0;
                        push_entry.ferr <= 1'b1;
                        push_entry.perr <= perr_q;
                        push_entry.data <= aligned;
                    end else if (brk_hit) begin
                        push            <= 1'b1;
                        push_entry.brk  <= 1'b1;
                        push_entry.ferr <= 1'b0;
                        push_entry.perr <= 1'b0;
                        push_entry.data <= '0;
                    end
                end
                S_REARM: begin
                    tcnt <= '0;
                end
                default: tcnt <= '0;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_brk_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  rx_entry_t     din,
    input  logic          pop,
    output rx_entry_t     dout,
    output logic          valid,
    output logic          drop,
    output logic          arrive,
    output logic [$clog2(DEPTH):0] count
);
    localparam int AW = $clog2(DEPTH);

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt, cnt_n;
    logic          full, pop_eff, push_ok;

    always_comb begin
        full    = (cnt == (AW+1)'(DEPTH));
        pop_eff = pop && (cnt != '0);
        push_ok = push && (!full || pop_eff);
        drop    = push && !push_ok;
        cnt_n   = cnt + {{AW{1'b0}}, push_ok} - {{AW{1'b0}}, pop_eff};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp     <= '0;
            rp     <= '0;
            cnt    <= '0;
            arrive <= 1'b0;
        end else begin
            if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop_eff) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt    <= cnt_n;
            arrive <= (cnt_n != '0) && ((cnt == '0) || pop_eff);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din;
    end

    assign dout  = mem[rp];
    assign valid = (cnt != '0);
    assign count = cnt;
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status (
    input  logic clk,
    input  logic rst_n,
    input  logic arrive,
    input  logic head_brk,
    input  logic drop,
    input  logic lsr_rd,
    output logic brk_stat,
    output logic ovr_stat
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_stat <= 1'b0;
            ovr_stat <= 1'b0;
        end else begin
            if (arrive && head_brk) brk_stat <= 1'b1;
            else if (lsr_rd)        brk_stat <= 1'b0;
            if (drop)               ovr_stat <= 1'b1;
            else if (lsr_rd)        ovr_stat <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
    import uart_rx_brk_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_two_stop,
    input  logic       pop,
    input  logic       lsr_rd,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       head_brk,
    output logic       head_ferr,
    output logic       head_perr,
    output logic       brk_stat,
    output logic       ovr_stat,
    output logic [$clog2(DEPTH):0] fifo_count
);
    logic      rxd_s, push, drop, arrive;
    rx_entry_t push_entry, head;

    uart_rx_sync #(.STAGES(2)) i_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
    );

    uart_rx_frame #(.OSR(OSR)) i_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd_s),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
        .push(push), .push_entry(push_entry)
    );

    uart_rx_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(push_entry),
        .pop(pop), .dout(head), .valid(rx_valid), .drop(drop),
        .arrive(arrive), .count(fifo_count)
    );

    uart_rx_status i_status (
        .clk(clk), .rst_n(rst_n), .arrive(arrive), .head_brk(head.brk),
        .drop(drop), .lsr_rd(lsr_rd), .brk_stat(brk_stat), .ovr_stat(ovr_stat)
    );

    assign rx_data   = head.data;
    assign head_brk  = head.brk;
    assign head_ferr = head.ferr;
    assign head_perr = head.perr;
endmodule

// File: rtl/uart_rx_brk_chk.sv
module uart_rx_brk_chk #(
    parameter int DEPTH = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pop,
    input logic       lsr_rd,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       head_brk,
    input logic       brk_stat,
    input logic       ovr_stat,
    input logic [$clog2(DEPTH):0] fifo_count
);
    p_count_bound_r13: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= ($clog2(DEPTH)+1)'(DEPTH));

    p_head_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !pop) |=> (rx_valid && $stable(rx_data)));

    p_brk_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && head_brk) |-> (rx_data == 8'h00));

    p_brk_at_head_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_stat) |-> $past(rx_valid && head_brk));

    p_brk_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(brk_stat) |-> $past(lsr_rd));

    p_ovr_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_stat) |-> ($past(fifo_count) == ($clog2(DEPTH)+1)'(DEPTH)));

    p_ovr_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovr_stat) |-> $past(lsr_rd));
endmodule

bind uart_rx_brk uart_rx_brk_chk #(.DEPTH(DEPTH)) i_chk (
    .clk(clk), .rst_n(rst_n), .pop(pop), .lsr_rd(lsr_rd),
    .rx_valid(rx_valid), .rx_data(rx_data), .head_brk(head_brk),
    .brk_stat(brk_stat), .ovr_stat(ovr_stat), .fifo_count(fifo_count)
);

// File: tb/test_uart_rx_brk.sv
module test_uart_rx_brk;
    localparam int OSR   = 16;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
    logic       pop = 1'b0, lsr_rd = 1'b0;
    logic       rx_valid, head_brk, head_ferr, head_perr, brk_stat, ovr_stat;
    logic [7:0] rx_data;
    logic [$clog2(DEPTH):0] fifo_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    uart_rx_brk #(.OSR(OSR), .DEPTH(DEPTH)) i_uart_rx_brk (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .pop(pop), .lsr_rd(lsr_rd),
        .rx_valid(rx_valid), .rx_data(rx_data), .head_brk(head_brk),
        .head_ferr(head_ferr), .head_perr(head_perr), .brk_stat(brk_stat),
        .ovr_stat(ovr_stat), .fifo_count(fifo_count)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold_line(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop2);
        int nb;
        logic p;
        nb = 5 + int'(cfg_len);
        p = cfg_par_odd;
        hold_line(1'b0, OSR);
        for (int i = 0; i < nb; i++) begin
            p ^= d[i];
            hold_line(d[i], OSR);
        end
        if (cfg_par_en) hold_line(p ^ bad_par, OSR);
        hold_line(1'b1, OSR);
        if (cfg_two_stop) hold_line(!bad_stop2, OSR);
        hold_line(1'b1, OSR);
    endtask

    task automatic pop_expect(input string req, input logic [7:0] d,
                              input bit b, input bit f, input bit p);
        check({req, " valid"}, int'(rx_valid), 1);
        check({req, " data"},  int'(rx_data), int'(d));
        check({req, " brk"},   int'(head_brk), int'(b));
        check({req, " ferr"},  int'(head_ferr), int'(f));
        check({req, " perr"},  int'(head_perr), int'(p));
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_status;
        lsr_rd = 1'b1;
        @(negedge clk);
        lsr_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 valid", int'(rx_valid), 0);
        check("R1 count", int'(fifo_count), 0);
        check("R1 brk_stat", int'(brk_stat), 0);
        check("R1 ovr_stat", int'(ovr_stat), 0);
    endtask

    task automatic t_basic;
        send_frame(8'hA5, 0, 0);
        send_frame(8'h3C, 0, 0);
        check("R13 count", int'(fifo_count), 2);
        pop_expect("R2 first", 8'hA5, 0, 0, 0);
        pop_expect("R13 second", 8'h3C, 0, 0, 0);
    endtask

    task automatic t_length;
        cfg_len = 2'd0;
        send_frame(8'hF5, 0, 0);
        pop_expect("R3 five bits", 8'h15, 0, 0, 0);
        cfg_len = 2'd2;
        send_frame(8'h6B, 0, 0);
        pop_expect("R3 seven bits", 8'h6B, 0, 0, 0);
        cfg_len = 2'd3;
    endtask

    task automatic t_parity;
        cfg_par_en = 1'b1;
        cfg_par_odd = 1'b0;
        send_frame(8'h37, 0, 0);
        pop_expect("R4 even ok", 8'h37, 0, 0, 0);
        send_frame(8'h37, 1, 0);
        pop_expect("R4 even bad", 8'h37, 0, 0, 1);
        cfg_par_odd = 1'b1;
        send_frame(8'hC1, 0, 0);
        pop_expect("R4 odd ok", 8'hC1, 0, 0, 0);
        cfg_par_en = 1'b0;
        cfg_par_odd = 1'b0;
    endtask

    task automatic t_stop;
        cfg_two_stop = 1'b1;
        send_frame(8'h5E, 0, 1);
        pop_expect("R5 second stop low", 8'h5E, 0, 1, 0);
        send_frame(8'h5E, 0, 0);
        pop_expect("R5 two stops ok", 8'h5E, 0, 0, 0);
        cfg_two_stop = 1'b0;
    endtask

    task automatic t_glitch;
        hold_line(1'b0, 4);
        hold_line(1'b1, 3 * OSR);
        check("R6 glitch ignored", int'(fifo_count), 0);
    endtask

    task automatic t_short_low;
        hold_line(1'b0, 156);
        hold_line(1'b1, 2 * OSR);
        check("R8 count", int'(fifo_count), 1);
        pop_expect("R8 zero frame", 8'h00, 0, 1, 0);
    endtask

    task automatic t_break;
        send_frame(8'h11, 0, 0);
        hold_line(1'b0, 400);
        check("R7 one entry per break", int'(fifo_count), 2);
        check("R10 status hidden behind head", int'(brk_stat), 0);
        hold_line(1'b1, 1);
        hold_line(1'b0, 300);
        check("R9 single high sample keeps blocked", int'(fifo_count), 2);
        hold_line(1'b1, 3 * OSR);
        send_frame(8'h5A, 0, 0);
        check("R9 rearmed", int'(fifo_count), 3);
        check("R10 still hidden", int'(brk_stat), 0);
        // pop now; next cycle the break entry's arrival meets the read strobe
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        lsr_rd = 1'b1;
        @(negedge clk);
        lsr_rd = 1'b0;
        @(negedge clk);
        check("R11 set wins over read", int'(brk_stat), 1);
        check("R7 head is zero", int'(rx_data), 0);
        check("R7 head brk tag", int'(head_brk), 1);
        read_status;
        check("R11 read clears", int'(brk_stat), 0);
        pop_expect("R7 break entry", 8'h00, 1, 0, 0);
        pop_expect("R9 next char", 8'h5A, 0, 0, 0);
    endtask

    task automatic t_overrun;
        for (int i = 0; i <= DEPTH; i++) send_frame(8'(8'h20 + i), 0, 0);
        check("R12 count full", int'(fifo_count), DEPTH);
        check("R12 ovr set", int'(ovr_stat), 1);
        read_status;
        check("R11 ovr cleared", int'(ovr_stat), 0);
        for (int i = 0; i < DEPTH; i++) pop_expect("R12 kept order", 8'(8'h20 + i), 0, 0, 0);
        check("R12 empty after drain", int'(rx_valid), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset;
        t_basic;
        t_length;
        t_parity;
        t_stop;
        t_glitch;
        t_short_low;
        t_break;
        t_overrun;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule